// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, frame by frame, whether a received Ethernet frame is kept. A frame parser presents the 48-bit destination address together with a one-cycle strobe. Exactly two clock cycles later the block returns a one-cycle decision with an accept flag and a high-priority flag.

A frame is accepted through any of five paths:
- one of 16 exact-match address slots;
- a 512-bit multicast hash table;
- a promiscuous mode bit;
- an all-multicast mode bit;
- a broadcast mode bit.

A second 512-bit hash table, indexed the same way as the first, raises only the priority flag. The hash index is computed inside the block from a CRC-32 of the address.

Host software programs the address slots, both hash tables and the mode bits through a simple word-wide register port. Writes are single-cycle. Read data follows the read address combinationally.

Top module: `rxaddr_filter`

## Requirements
- R1: A strobe on `frm_vld` yields `dec_vld` high for exactly one cycle, two rising edges later. While `dec_vld` is low, `dec_accept` and `dec_prio` are low.
- R2: Exact slot i (0..15) occupies register words 4i, 4i+1 and 4i+2, holding destination bits 47:32, 31:16 and 15:0 respectively. Bits 47:40 are the first address byte. A destination equal to all 48 bits of any slot is accepted.
- R3: A slot holding all zeros never matches, so writing zeros to a slot removes its address.
- R4: The hash index h is bits 31:23 of a CRC-32 over the six address bytes, first byte first and each byte least significant bit first. The CRC uses polynomial 0x04C11DB7, starts from all ones and has no final inversion. Bits h[8:4] select multicast hash word 0x40+h[8:4], and h[3:0] selects the bit within that word.
- R5: A multicast frame (destination bit 40 set) whose hash bit is set is accepted. A unicast frame is never accepted through the hash table, even when its hash bit is set.
- R6: The priority table occupies words 0x60..0x7F and is indexed like R4. `dec_prio` equals the selected bit for any frame, and the priority table never causes acceptance.
- R7: Mode register 0x80 bit 0 (promiscuous) accepts every frame.
- R8: Mode bit 1 (all-multicast) accepts every frame with destination bit 40 set, and no unicast frame through that path.
- R9: Mode bit 2 (broadcast) accepts the all-ones address. Without mode bit 2, and with no other path, the all-ones address is rejected.
- R10: Reads return the last value written to slot words, hash words and priority words. Mode reads return bits 2:0 with the upper bits zero. The fourth word of each slot, and addresses above 0x80, read zero, and writes to them have no effect.
- R11: Reset (synchronous, active low) clears every slot, both hash tables and the mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frm_vld | input | 1 | One-cycle strobe: destination address valid |
| frm_dst | input | 48 | Destination address; bits 47:40 are the first byte |
| reg_wen | input | 1 | Host write enable |
| reg_addr | input | 8 | Host word address |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data for `reg_addr` |
| dec_vld | output | 1 | Decision valid, one cycle |
| dec_accept | output | 1 | Frame accepted |
| dec_prio | output | 1 | Frame flagged high priority |

## Verification
The latency assertion takes for granted that `frm_vld` is held low while reset is applied. It also assumes that the mode register is not rewritten in the cycle between strobe and decision, because the promiscuous and all-multicast properties sample the mode one cycle before the decision is registered. The directed stimulus keeps to both assumptions: inputs are quiet throughout reset, and every table or mode write finishes before the next strobe. Each frame is fully retired before the next one starts, so decisions never overlap.

// File: rtl/rxaf_pkg.sv
// Shared types and the address hash function for the receive address filter.
// Assumes a 48-bit address whose first transmitted byte sits in bits 47:40.
package rxaf_pkg;

    localparam int ADDR_BITS = 48;
    localparam int ADDR_BYTES = ADDR_BITS / 8;
    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

    // Mode register layout; bit 0 is promiscuous.
    typedef struct packed {
        logic bcast_en;
        logic allmc_en;
        logic promisc;
    } rxaf_mode_t;

    // CRC-32, MSB-first register, data fed byte by byte with each byte LSB first.
    function automatic logic [31:0] addr_crc(input logic [ADDR_BITS-1:0] a);
        logic [31:0] c;
        logic fb;
        c = '1;
        for (int b = 0; b < ADDR_BYTES; b++) begin
            for (int k = 0; k < 8; k++) begin
                fb = c[31] ^ a[ADDR_BITS - 8 - 8*b + k];
                c = {c[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/rxaf_crc_hash.sv
// Combinational hash index generator: top HASH_BITS of the address CRC.
// Assumes the caller registers the result; the depth is one 48-step XOR network.
module rxaf_crc_hash #(
    parameter int HASH_BITS = 9
) (
    input  logic [rxaf_pkg::ADDR_BITS-1:0] addr,
    output logic [HASH_BITS-1:0]           idx
);
    logic [31:0] crc;

    // Hash the address and keep the most significant bits.
    always_comb begin
        crc = rxaf_pkg::addr_crc(addr);
        idx = crc[31 -: HASH_BITS];
    end
endmodule

// File: rtl/rxaf_exact_tbl.sv
// Exact-match address table: NUM_EXACT slots of three 16-bit words each.
// Word 0 holds address bits 47:32. An all-zero slot is treated as empty.
// Assumes the caller never writes with wr_word equal to 3.
module rxaf_exact_tbl #(
    parameter int NUM_EXACT = 16,
    localparam int ENT_W = $clog2(NUM_EXACT),
    localparam int WPE = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ENT_W-1:0]               wr_ent,
    input  logic [1:0]                     wr_word,
    input  logic [15:0]                    wr_data,
    input  logic [ENT_W-1:0]               rd_ent,
    input  logic [1:0]                     rd_word,
    output logic [15:0]                    rd_data,
    input  logic [rxaf_pkg::ADDR_BITS-1:0] lk_addr,
    output logic                           lk_hit
);
    logic [NUM_EXACT-1:0][WPE-1:0][15:0] tbl;
    logic [NUM_EXACT-1:0]                slot_match;

    // Storage: clear on reset, host writes one word per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl <= '0;
        end else if (wr_en && wr_word != 2'd3) begin
            tbl[wr_ent][wr_word] <= wr_data;
        end
    end

    // Host read port; the fourth word of a slot reads zero.
    always_comb begin
        rd_data = '0;
        if (rd_word != 2'd3) rd_data = tbl[rd_ent][rd_word];
    end

    // One comparator per slot; an empty slot is masked.
    for (genvar g = 0; g < NUM_EXACT; g++) begin : g_slot
        logic [rxaf_pkg::ADDR_BITS-1:0] slot_addr;
        assign slot_addr = {tbl[g][0], tbl[g][1], tbl[g][2]};
        assign slot_match[g] = (|slot_addr) && (slot_addr == lk_addr);
    end

    assign lk_hit = |slot_match;

    // R3
    zero_addr_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_addr == '0) |-> !lk_hit);

    // R10
    exact_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_word != 2'd3) |=> (tbl[$past(wr_ent)][$past(wr_word)] == $past(wr_data)));
endmodule

// File: rtl/rxaf_hash_tbl.sv
// Bit-addressed hash table of WORDS words of WORD_W bits.
// The lookup index is {word, bit}. Host access is one word per cycle.
// Assumes wr_idx and rd_idx are already in range.
module rxaf_hash_tbl #(
    parameter int WORDS = 32,
    parameter int WORD_W = 16,
    localparam int IDX_W = $clog2(WORDS),
    localparam int BIT_W = $clog2(WORD_W)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [WORD_W-1:0]        rd_data,
    input  logic [IDX_W+BIT_W-1:0]   look_idx,
    output logic                     look_bit
);
    logic [WORDS-1:0][WORD_W-1:0] mem;
    logic [WORD_W-1:0]            look_word;

    // Storage: cleared on reset, written whole words by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) mem <= '0;
        else if (wr_en) mem[wr_idx] <= wr_data;
    end

    // Host read and lookup: upper index picks a word, lower picks the bit.
    always_comb begin
        rd_data   = mem[rd_idx];
        look_word = mem[look_idx[IDX_W+BIT_W-1:BIT_W]];
        look_bit  = look_word[look_idx[BIT_W-1:0]];
    end

    // R10
    hash_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/rxaddr_filter.sv
// Receive address filter top.
// Stage 1 registers the exact-match result, the hash index and the address
// class. Stage 2 looks up both hash tables and forms the decision.
// Host register map (word addresses):
//   slots at 0..4*NUM_EXACT-1, multicast hash words next, priority hash words
//   after that, then the mode register.
// Assumes frm_vld is low during reset and is a single-cycle strobe.
module rxaddr_filter #(
    parameter int NUM_EXACT = 16,
    parameter int HASH_BITS = 9,
    parameter int WORD_W = 16,
    localparam int HASH_SIZE = 1 << HASH_BITS,
    localparam int HASH_WORDS = HASH_SIZE / WORD_W,
    localparam int WSEL_W = $clog2(HASH_WORDS),
    localparam int ENT_W = $clog2(NUM_EXACT),
    localparam int EXACT_SPAN = NUM_EXACT * 4,
    localparam int HASH_BASE = EXACT_SPAN,
    localparam int PRIO_BASE = HASH_BASE + HASH_WORDS,
    localparam int MODE_ADDR = PRIO_BASE + HASH_WORDS,
    localparam int ADDR_W = $clog2(MODE_ADDR + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frm_vld,
    input  logic [47:0]          frm_dst,
    input  logic                 reg_wen,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic                 dec_vld,
    output logic                 dec_accept,
    output logic                 dec_prio
);
    import rxaf_pkg::*;

    localparam logic [47:0] BCAST_ADDR = '1;

    // Host address decode
    logic                 in_exact, in_hash, in_prio, in_mode;
    logic [ADDR_W-1:0]    hash_off, prio_off;
    logic [ENT_W-1:0]     ent_sel;
    logic [1:0]           word_sel;
    logic [WORD_W-1:0]    exact_rd, hash_rd, prio_rd;

    // Mode register and pipeline state
    rxaf_mode_t           mode_q;
    logic                 s1_vld, s1_hit, s1_mc, s1_bc;
    logic [HASH_BITS-1:0] s1_idx;
    logic                 lk_hit;
    logic [HASH_BITS-1:0] hash_idx;
    logic                 hash_bit, prio_bit;

    // Split the host address into regions and in-region offsets.
    always_comb begin
        in_exact = reg_addr <  ADDR_W'(EXACT_SPAN);
        in_hash  = (reg_addr >= ADDR_W'(HASH_BASE)) && (reg_addr < ADDR_W'(PRIO_BASE));
        in_prio  = (reg_addr >= ADDR_W'(PRIO_BASE)) && (reg_addr < ADDR_W'(MODE_ADDR));
        in_mode  = reg_addr == ADDR_W'(MODE_ADDR);
        hash_off = reg_addr - ADDR_W'(HASH_BASE);
        prio_off = reg_addr - ADDR_W'(PRIO_BASE);
        ent_sel  = reg_addr[ENT_W+1:2];
        word_sel = reg_addr[1:0];
    end

    rxaf_exact_tbl #(.NUM_EXACT(NUM_EXACT)) exact_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wen && in_exact),
        .wr_ent  (ent_sel),
        .wr_word (word_sel),
        .wr_data (reg_wdata[15:0]),
        .rd_ent  (ent_sel),
        .rd_word (word_sel),
        .rd_data (exact_rd[15:0]),
        .lk_addr (frm_dst),
        .lk_hit  (lk_hit)
    );

    rxaf_crc_hash #(.HASH_BITS(HASH_BITS)) crc_i (
        .addr (frm_dst),
        .idx  (hash_idx)
    );

    rxaf_hash_tbl #(.WORDS(HASH_WORDS), .WORD_W(WORD_W)) mchash_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wen && in_hash),
        .wr_idx   (hash_off[WSEL_W-1:0]),
        .wr_data  (reg_wdata),
        .rd_idx   (hash_off[WSEL_W-1:0]),
        .rd_data  (hash_rd),
        .look_idx (s1_idx),
        .look_bit (hash_bit)
    );

    rxaf_hash_tbl #(.WORDS(HASH_WORDS), .WORD_W(WORD_W)) priohash_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wen && in_prio),
        .wr_idx   (prio_off[WSEL_W-1:0]),
        .wr_data  (reg_wdata),
        .rd_idx   (prio_off[WSEL_W-1:0]),
        .rd_data  (prio_rd),
        .look_idx (s1_idx),
        .look_bit (prio_bit)
    );

    // Mode register: three enable bits, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '0;
        else if (reg_wen && in_mode) mode_q <= rxaf_mode_t'(reg_wdata[2:0]);
    end

    // Host read multiplexer; unmapped addresses read zero.
    always_comb begin
        reg_rdata = '0;
        if (in_exact)     reg_rdata = exact_rd;
        else if (in_hash) reg_rdata = hash_rd;
        else if (in_prio) reg_rdata = prio_rd;
        else if (in_mode) reg_rdata = WORD_W'(mode_q);
    end

    // Stage 1: capture exact result, hash index and address class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_hit <= 1'b0;
            s1_mc  <= 1'b0;
            s1_bc  <= 1'b0;
            s1_idx <= '0;
        end else begin
            s1_vld <= frm_vld;
            s1_hit <= frm_vld && lk_hit;
            s1_mc  <= frm_vld && frm_dst[40];
            s1_bc  <= frm_vld && (frm_dst == BCAST_ADDR);
            s1_idx <= hash_idx;
        end
    end

    // Stage 2: combine all acceptance paths and the priority lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_vld    <= 1'b0;
            dec_accept <= 1'b0;
            dec_prio   <= 1'b0;
        end else begin
            dec_vld    <= s1_vld;
            dec_accept <= s1_vld && (mode_q.promisc || s1_hit ||
                                     (mode_q.bcast_en && s1_bc) ||
                                     (s1_mc && (mode_q.allmc_en || hash_bit)));
            dec_prio   <= s1_vld && prio_bit;
        end
    end

    // R1
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld |=> ##1 dec_vld);

    // R1
    idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_vld |-> (!dec_accept && !dec_prio));

    // R7
    promisc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && mode_q.promisc) |=> dec_accept);

    // R8
    allmulti_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_mc && mode_q.allmc_en) |=> dec_accept);

    // R5
    ucast_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && !s1_mc && !s1_hit && mode_q == '0) |=> !dec_accept);
endmodule

// File: tb/rxaddr_filter_tb.sv
// Directed bench for the receive address filter: one task per scenario.
module rxaddr_filter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HB = 64;
    localparam int PB = 96;
    localparam int MA = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_vld = 1'b0;
    logic [47:0] frm_dst = '0;
    logic        reg_wen = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        dec_vld, dec_accept, dec_prio;

    int checks = 0;
    int errors = 0;
    bit reported = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxaddr_filter dut_i (
        .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm_dst(frm_dst),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dec_vld(dec_vld), .dec_accept(dec_accept),
        .dec_prio(dec_prio)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    // Serial CRC model from the R4 definition, returns the 9-bit index.
    function automatic logic [8:0] model_idx(input logic [47:0] a);
        logic [47:0] s;
        logic [31:0] r;
        logic t;
        for (int by = 0; by < 6; by++)
            for (int bt = 0; bt < 8; bt++)
                s[47 - (by*8 + bt)] = a[40 - 8*by + bt];
        r = 32'hFFFF_FFFF;
        for (int i = 47; i >= 0; i--) begin
            t = r[31] ^ s[i];
            r = r << 1;
            if (t) r = r ^ 32'h04C1_1DB7;
        end
        return r[31:23];
    endfunction

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = 8'(a); reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd_chk(input int a, input logic [15:0] exp, input string req);
        @(negedge clk);
        reg_addr = 8'(a);
        #1;
        chk(req, $sformatf("read @%0h", a), 32'(reg_rdata), 32'(exp));
    endtask

    task automatic set_slot(input int s, input logic [47:0] a);
        wr(4*s + 0, a[47:32]);
        wr(4*s + 1, a[31:16]);
        wr(4*s + 2, a[15:0]);
    endtask

    // Send one frame; check latency, accept and priority (R1 plus caller's tag).
    task automatic send(input logic [47:0] a, input bit ea, input bit ep, input string req);
        @(negedge clk);
        frm_vld = 1'b1; frm_dst = a;
        @(negedge clk);
        frm_vld = 1'b0;
        chk("R1", "dec_vld one cycle after strobe", 32'(dec_vld), 0);
        @(negedge clk);
        chk("R1", "dec_vld two cycles after strobe", 32'(dec_vld), 1);
        chk(req, $sformatf("accept for %012h", a), 32'(dec_accept), 32'(ea));
        chk(req, $sformatf("prio for %012h", a), 32'(dec_prio), 32'(ep));
        @(negedge clk);
        chk("R1", "dec_vld single cycle", 32'(dec_vld), 0);
        chk("R1", "flags low when idle", 32'({dec_accept, dec_prio}), 0);
    endtask

    task automatic clear_hash(input int base);
        for (int w = 0; w < 32; w++) wr(base + w, 16'h0);
    endtask

    task automatic t_reset();
        chk("R11", "dec_vld after reset", 32'(dec_vld), 0);
        rd_chk(MA, 16'h0, "R11");
        rd_chk(HB + 7, 16'h0, "R11");
        rd_chk(PB + 31, 16'h0, "R11");
        rd_chk(0, 16'h0, "R11");
        send(48'hFFFF_FFFF_FFFF, 1'b0, 1'b0, "R11");
    endtask

    task automatic t_regs();
        wr(4*3 + 1, 16'hBEEF);
        rd_chk(4*3 + 1, 16'hBEEF, "R10");
        wr(4*3 + 3, 16'h1234);
        rd_chk(4*3 + 3, 16'h0, "R10");
        rd_chk(4*3 + 1, 16'hBEEF, "R10");
        wr(HB + 5, 16'hA5A5);
        rd_chk(HB + 5, 16'hA5A5, "R10");
        wr(PB + 9, 16'h0F0F);
        rd_chk(PB + 9, 16'h0F0F, "R10");
        wr(MA, 16'hFFF8);
        rd_chk(MA, 16'h0, "R10");
        wr(MA + 5, 16'hFFFF);
        rd_chk(MA + 5, 16'h0, "R10");
        wr(4*3 + 1, 16'h0);
        wr(HB + 5, 16'h0);
        wr(PB + 9, 16'h0);
    endtask

    task automatic t_exact();
        logic [47:0] sta = 48'h0211_2233_4455;
        logic [47:0] grp = 48'h0100_5E00_00FB;
        set_slot(0, sta);
        rd_chk(0, 16'h0211, "R2");
        rd_chk(2, 16'h4455, "R2");
        send(sta, 1'b1, 1'b0, "R2");
        send(sta ^ 48'h1, 1'b0, 1'b0, "R2");
        send(sta ^ 48'h8000_0000_0000, 1'b0, 1'b0, "R2");
        set_slot(15, grp);
        send(grp, 1'b1, 1'b0, "R2");
        set_slot(15, 48'h0);
        send(grp, 1'b0, 1'b0, "R3");
        send(48'h0, 1'b0, 1'b0, "R3");
    endtask

    task automatic t_hash();
        logic [47:0] m = 48'h0133_4455_6677;
        logic [8:0]  h = model_idx(m);
        wr(HB + int'(h[8:4]), 16'(1) << (h[3:0] ^ 4'd1));
        send(m, 1'b0, 1'b0, "R4");
        wr(HB + int'(h[8:4]), 16'(1) << h[3:0]);
        send(m, 1'b1, 1'b0, "R4");
        wr(HB + int'(h[8:4]), 16'h0);
        for (int w = 0; w < 32; w++) wr(HB + w, 16'hFFFF);
        send(48'h00AA_BBCC_DDEE, 1'b0, 1'b0, "R5");
        send(48'h01AA_BBCC_DDEE, 1'b1, 1'b0, "R5");
        clear_hash(HB);
        send(48'h01AA_BBCC_DDEE, 1'b0, 1'b0, "R5");
    endtask

    task automatic t_prio();
        logic [47:0] m = 48'h0150_6070_8090;
        logic [47:0] u = 48'h0012_3456_789A;
        logic [47:0] o = m ^ 48'h1;
        logic [8:0]  hm = model_idx(m);
        logic [8:0]  hu = model_idx(u);
        if (model_idx(o) == hm) o = m ^ 48'h100;
        wr(PB + int'(hm[8:4]), 16'(1) << hm[3:0]);
        send(m, 1'b0, 1'b1, "R6");
        if (model_idx(o) != hm) send(o, 1'b0, 1'b0, "R6");
        clear_hash(PB);
        wr(PB + int'(hu[8:4]), 16'(1) << hu[3:0]);
        send(u, 1'b0, 1'b1, "R6");
        clear_hash(PB);
    endtask

    task automatic t_modes();
        wr(MA, 16'h1);
        send(48'h0098_7654_3210, 1'b1, 1'b0, "R7");
        wr(MA, 16'h2);
        send(48'h0398_7654_3210, 1'b1, 1'b0, "R8");
        send(48'h0298_7654_3210, 1'b0, 1'b0, "R8");
        wr(MA, 16'h4);
        send(48'hFFFF_FFFF_FFFF, 1'b1, 1'b0, "R9");
        send(48'hFFFF_FFFF_FFFE, 1'b0, 1'b0, "R9");
        wr(MA, 16'h0);
        send(48'hFFFF_FFFF_FFFF, 1'b0, 1'b0, "R9");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_exact();
        t_hash();
        t_prio();
        t_modes();
        repeat (2) @(negedge clk);
        report();
        $finish;
    end
endmodule